// File: doc/BRIEF.md
# Paged Scatter-Gather DMA Address Generator

This block generates the memory addresses for a DMA engine that moves bytes between a disk-style peripheral and a buffer scattered over a fixed number of 4 KB physical pages. Software uses a small register bus to program a start register and a table of page numbers, one per 4 KB segment. The start register holds a byte offset that applies to the first page only, plus a direction bit. With the default parameters the table has 256 entries of 16 bits.

While `run` is high and no overrun has occurred, the block offers an address on a valid/ready handshake. The address is the current table entry shifted left by 12, joined to the current in-page offset, which gives a 28-bit physical address. Each accepted beat moves the walk forward by one byte. When the offset rolls over from 0xFFF, the walk moves to the next table entry, and that page starts at offset 0. Writing zero to the flush register restarts the walk.

Register map (byte addresses, default parameters). The start register is at 0x000: bit 15 is the direction, bits [11:0] are the offset, and bits [14:12] read as zero. The flush register is at 0x004. The page table occupies 0x400 to 0x7FC, and entry i is at 0x400 + 4*i. In general the table base is 2^(IDX_W+2).

Top module: `sg_dma_addr_gen`

## Requirements
- R1: After reset, `overrun` is 0, `addr_valid` is 0, the start register reads 0 and every page entry reads 0.
- R2: A write to the start register stores bit 15 and bits [11:0]. A read returns those bits, with bits [14:12] read as zero.
- R3: Page entry i is written and read back unchanged at table base + 4*i. An entry that has not been written keeps its value.
- R4: Right after a flush, `dma_addr` equals {entry 0, start offset}. At any point it equals {current entry, current offset}.
- R5: Each beat accepted with `addr_valid` and `addr_ready` both high adds 1 to the offset. While `addr_valid` is high and `addr_ready` is low, `dma_addr` and `dma_to_mem` hold steady.
- R6: When an accepted beat takes the offset from 0xFFF to 0x000, the walk moves to the next table entry. Every page after the first starts at offset 0.
- R7: `dma_to_mem` equals bit 15 of the start register: 1 means peripheral to memory, 0 means memory to peripheral.
- R8: A write of 0 to the flush register sets the walk back to entry 0 at the start offset and clears `overrun`. A nonzero write to the flush register has no effect.
- R9: Once the beat at offset 0xFFF of the last entry is accepted, `overrun` is set and `addr_valid` is 0. Both stay that way until the next flush.
- R10: `addr_valid` is high exactly when `run` is high and `overrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Register bus write enable |
| bus_addr | input | IDX_W+4 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| run | input | 1 | Enables address issue |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Address accepted by DMA datapath |
| dma_addr | output | PG_W+OFS_W | Physical byte address |
| dma_to_mem | output | 1 | Direction, 1 = peripheral to memory |
| overrun | output | 1 | Table exhausted, sticky until flush |

## Verification
Register reads are combinational, so the bench samples read data in the same cycle it drives the address. Register writes, flushes and accepted beats all take effect at the next rising edge. The address, valid and overrun outputs are decoded straight from the walk registers, so each new value appears one edge after its cause. The bench drives inputs 1 ns after a rising edge, and after every edge it compares against the value that edge should have produced. During the full table walk it predicts the address of every beat k as {entry k/4096, k mod 4096}. To keep that walk short, the bench builds the block with eight pages.

// File: rtl/sg_dma_addr_gen.sv
module sg_dma_addr_gen #(
  parameter int OFS_W = 12,
  parameter int PG_W  = 16,
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [IDX_W+3:0]        bus_addr,
  input  logic [15:0]             bus_wdata,
  output logic [15:0]             bus_rdata,
  input  logic                    run,
  output logic                    addr_valid,
  input  logic                    addr_ready,
  output logic [PG_W+OFS_W-1:0]   dma_addr,
  output logic                    dma_to_mem,
  output logic                    overrun
);
  localparam int NPG = 1 << IDX_W;
  localparam int BAW = IDX_W + 4;
  localparam int CW  = IDX_W + OFS_W + 1;

  logic [PG_W-1:0]  pg_q [NPG];
  logic [OFS_W-1:0] sofs_q;
  logic             dir_q;
  logic [CW-1:0]    cnt_q;
  logic             ovr_q;

  wire wr        = bus_sel & bus_we;
  wire start_hit = bus_addr == BAW'(0);
  wire flush_hit = bus_addr == BAW'(4);
  wire tbl_hit   = (bus_addr[BAW-1:IDX_W+2] == 2'b01) && (bus_addr[1:0] == 2'b00);
  wire [IDX_W-1:0] tidx = bus_addr[IDX_W+1:2];
  wire flush     = wr & flush_hit & (bus_wdata == 16'h0);

  wire [CW-1:0] pos    = cnt_q + CW'(sofs_q);
  wire [CW-1:0] pos_nx = pos + CW'(1);
  wire          beat   = addr_valid & addr_ready;

  assign addr_valid = run & ~ovr_q;
  assign overrun    = ovr_q;
  assign dma_to_mem = dir_q;
  assign dma_addr   = {pg_q[pos[CW-2:OFS_W]], pos[OFS_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sofs_q <= '0;
      dir_q  <= 1'b0;
    end else if (wr && start_hit) begin
      sofs_q <= bus_wdata[OFS_W-1:0];
      dir_q  <= bus_wdata[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (flush) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= cnt_q + CW'(1);
      if (pos_nx[CW-1]) ovr_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPG; i++) begin : g_pg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                pg_q[i] <= '0;
      else if (wr && tbl_hit && tidx == IDX_W'(i)) pg_q[i] <= bus_wdata[PG_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) begin
      bus_rdata[15]        = dir_q;
      bus_rdata[OFS_W-1:0] = sofs_q;
    end else if (tbl_hit) begin
      bus_rdata[PG_W-1:0] = pg_q[tidx];
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && !wr |=> $stable(dma_addr) && $stable(dma_to_mem));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !wr && (pos[OFS_W-1:0] != '1) |=> dma_addr == $past(dma_addr) + 1'b1);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !wr && (&pos[OFS_W-1:0]) && !pos_nx[CW-1] |=> dma_addr[OFS_W-1:0] == '0);

  p_no_valid_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !addr_valid);

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !flush |=> overrun);

  p_flush_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !overrun);

  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !addr_valid);
endmodule

// File: tb/sg_dma_addr_gen_bench.sv
module sg_dma_addr_gen_bench;
  localparam int IDX_W = 3;
  localparam int NPG   = 1 << IDX_W;
  localparam int BAW   = IDX_W + 4;
  localparam int TBASE = 1 << (IDX_W + 2);

  localparam logic [15:0] PGV [NPG] = '{16'h0123, 16'hABCD, 16'h0FFF, 16'hFFFF,
                                        16'h8000, 16'h1234, 16'h0001, 16'h7E5A};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0, run = 0, addr_ready = 0;
  logic [BAW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic addr_valid, dma_to_mem, overrun;
  logic [27:0] dma_addr;

  int nvec = 0, nerr = 0;

  always #2 clk = ~clk;

  sg_dma_addr_gen #(.IDX_W(IDX_W)) u_sg_dma_addr_gen (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run(run), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .dma_addr(dma_addr), .dma_to_mem(dma_to_mem), .overrun(overrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = BAW'(a); bus_wdata = d;
    step();
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input string req, input int a, input logic [15:0] exp);
    bus_sel = 1; bus_we = 0; bus_addr = BAW'(a); #1;
    chk(req, {16'h0, bus_rdata}, {16'h0, exp});
    bus_sel = 0;
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    step(); rst_n = 1; step();
    // R1 reset state
    chk("R1 overrun", {31'h0, overrun}, 0);
    chk("R1 valid", {31'h0, addr_valid}, 0);
    rd("R1 start", 0, 16'h0);
    for (int i = 0; i < NPG; i++) rd("R1 page", TBASE + 4*i, 16'h0);

    // R3 vector table: program then read back
    for (int i = 0; i < NPG; i++) wr(TBASE + 4*i, PGV[i]);
    for (int i = 0; i < NPG; i++) rd("R3 page readback", TBASE + 4*i, PGV[i]);

    // R2 start register with junk in [14:12]
    wr(0, 16'hFFFE);
    rd("R2 start readback", 0, 16'h8FFE);
    chk("R7 dir to mem", {31'h0, dma_to_mem}, 1);

    // R10 run low -> no valid
    wr(4, 16'h0);
    chk("R10 run low", {31'h0, addr_valid}, 0);
    run = 1; #1;
    chk("R10 run high", {31'h0, addr_valid}, 1);
    chk("R4 first addr", {4'h0, dma_addr}, {4'h0, PGV[0], 12'hFFE});

    // R5 hold while not ready
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 hold", {4'h0, dma_addr}, {4'h0, PGV[0], 12'hFFE});
    end
    addr_ready = 1; step();
    chk("R5 step", {4'h0, dma_addr}, {4'h0, PGV[0], 12'hFFF});
    step(); addr_ready = 0;
    chk("R6 page advance", {4'h0, dma_addr}, {4'h0, PGV[1], 12'h000});

    // R8 nonzero flush ignored
    wr(4, 16'h0005);
    chk("R8 nonzero flush ignored", {4'h0, dma_addr}, {4'h0, PGV[1], 12'h000});
    wr(4, 16'h0);
    chk("R8 flush restart", {4'h0, dma_addr}, {4'h0, PGV[0], 12'hFFE});

    // Full walk from offset 0, direction to peripheral
    wr(0, 16'h0000);
    chk("R7 dir to periph", {31'h0, dma_to_mem}, 0);
    wr(4, 16'h0);
    addr_ready = 1;
    for (int k = 0; k < NPG * 4096; k++) begin
      #0;
      chk("R6 walk addr", {4'h0, dma_addr}, {4'h0, PGV[k >> 12], 12'(k)});
      step();
    end
    chk("R9 overrun set", {31'h0, overrun}, 1);
    chk("R9 valid low", {31'h0, addr_valid}, 0);
    for (int i = 0; i < 5; i++) step();
    chk("R9 overrun sticky", {31'h0, overrun}, 1);
    addr_ready = 0;
    wr(4, 16'h0);
    chk("R8 flush clears overrun", {31'h0, overrun}, 0);
    chk("R8 valid back", {31'h0, addr_valid}, 1);
    chk("R4 addr after flush", {4'h0, dma_addr}, {4'h0, PGV[0], 12'h000});

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule